// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `W` bits (9 by default) over several clock cycles and returns a signed product of `2*W` bits. It uses radix-2 Booth recoding. An accumulator and a multiplier shift register form one long register pair that shifts right arithmetically, and one extra flip-flop keeps the bit that left the multiplier register on the last shift. On each step the controller reads the multiplier register's lowest bit together with that flip-flop. When the pair asks for arithmetic, the controller inserts one cycle that adds the latched multiplicand to the accumulator or subtracts it. The shift then follows in its own cycle.

To use the block, the caller pulses `start` for one cycle with both operands on the inputs. The block latches them, raises `busy` while it works, and pulses `done` for one cycle when the last shift is complete. The product stays on its port until the next accepted start. The accumulator carries one guard bit above the operand width, so the most negative multiplicand can be subtracted without overflow.

Top module: `booth_seq_mult`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are low and `product` reads zero.
- R2: For any two `W`-bit signed operands, `product` is the exact signed product in `2*W` bits once `done` is high.
- R3: The step decision uses the pair (multiplier-register LSB, last-shifted-out bit F). Pair 0/1 adds the multiplicand to the accumulator, pair 1/0 subtracts it, and pairs 0/0 and 1/1 do no arithmetic. F is zero after a start.
- R4: Each step is a one-bit arithmetic right shift of the accumulator and multiplier pair. The accumulator MSB keeps its value, the accumulator LSB enters the multiplier MSB, and the multiplier LSB moves into F.
- R5: Exactly `W` shifts are made, and an arithmetic cycle is inserted only before the shifts that need one. The start edge is edge 0, and the last shift happens at edge `W + n`, where `n` counts the bit positions i (0..W-1) at which multiplier bit i differs from bit i-1, with bit -1 taken as 0.
- R6: `done` is high for exactly the one cycle after the last shift, with `busy` low in that cycle. `product` keeps its value afterwards until the next accepted start.
- R7: A `start` pulse while `busy` is high is ignored. Changes on the operand inputs after the start cycle do not affect the result or the latency.
- R8: A multiplicand of -2^(W-1) gives the correct product for every multiplier, including -2^(W-1) times -2^(W-1).
- R9: Asserting reset in the middle of an operation returns the block to idle with the product cleared. A later start then works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (accepted when not busy) |
| multiplicand | input | W | Signed multiplicand, sampled on an accepted start |
| multiplier | input | W | Signed multiplier, sampled on an accepted start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the final shift |
| product | output | 2*W | Signed product, held until the next start |

## Verification
On every cycle, the assertions check the following. An arithmetic cycle happens only when the decision pair calls for one. The accumulator then changes by exactly plus or minus the sign-extended multiplicand. Each shift keeps the accumulator sign and moves the multiplier LSB into F. `done` is a single pulse that never overlaps `busy`, and the latched multiplicand stays fixed while busy. Only the bench's scenarios can show that the full product is correct, that the latency depends on the multiplier's bit transitions, and that the result ignores mid-run starts and operand changes. The bench also checks recovery from a reset in the middle of an operation.

// File: rtl/booth_pkg.sv
package booth_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_STEP  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_DONE  = 2'd3
   } booth_state_e;
endpackage

// File: rtl/booth_shreg.sv
// Right-shift register with parallel load (priority) and serial MSB input.
module booth_shreg #(
   parameter int WIDTH = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld,
   input  logic             sright,
   input  logic [WIDTH-1:0] din,
   input  logic             sin,
   output logic [WIDTH-1:0] q
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("booth_shreg: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (ld)
         q <= din;
      else if (sright)
         q <= {sin, q[WIDTH-1:1]};
   end

   // R4: a shift moves every bit down one place and takes the serial bit at the top
   a_r4_shift_path: assert property (@(posedge clk) disable iff (rst)
      (sright && !ld) |=> (q[WIDTH-1] == $past(sin)) && (q[WIDTH-2:0] == $past(q[WIDTH-1:1])));
endmodule

// File: rtl/booth_addsub.sv
// Adder/subtractor: q = a + b when sub = 0, q = a - b when sub = 1.
module booth_addsub #(
   parameter int WIDTH      = 10,
   parameter bit INVERT_ADD = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] q
);
   generate
      if (INVERT_ADD) begin : g_invert
         // one adder, operand inverted and carry injected for subtraction
         logic [WIDTH-1:0] b_x;
         assign b_x = b ^ {WIDTH{sub}};
         assign q   = a + b_x + WIDTH'(sub);
      end else begin : g_mux
         logic [WIDTH-1:0] s_add;
         logic [WIDTH-1:0] s_sub;
         assign s_add = a + b;
         assign s_sub = a - b;
         assign q     = sub ? s_sub : s_add;
      end
   endgenerate
endmodule

// File: rtl/booth_ctrl.sv
// Sequencer: one arithmetic cycle when requested, then one shift, for STEPS steps.
module booth_ctrl
   import booth_pkg::*;
#(
   parameter int STEPS = 9
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic mult,
   output logic init,
   output logic arith,
   output logic shift,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(STEPS + 1);

   booth_state_e st_q, st_d;
   logic [CW-1:0] cnt_q;
   logic          last;

   generate
      if (STEPS < 2) begin : g_bad_steps
         $error("booth_ctrl: STEPS must be at least 2");
      end
   endgenerate

   assign last = (cnt_q == CW'(STEPS - 1));

   always_comb begin
      st_d  = st_q;
      init  = 1'b0;
      arith = 1'b0;
      shift = 1'b0;
      unique case (st_q)
         ST_IDLE, ST_DONE: begin
            if (start) begin
               init = 1'b1;
               st_d = ST_STEP;
            end else begin
               st_d = ST_IDLE;
            end
         end
         ST_STEP: begin
            if (mult) begin
               arith = 1'b1;
               st_d  = ST_SHIFT;
            end else begin
               shift = 1'b1;
               st_d  = last ? ST_DONE : ST_STEP;
            end
         end
         ST_SHIFT: begin
            shift = 1'b1;
            st_d  = last ? ST_DONE : ST_STEP;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (init)
            cnt_q <= '0;
         else if (shift)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign busy = (st_q == ST_STEP) || (st_q == ST_SHIFT);
   assign done = (st_q == ST_DONE);

   // R3: arithmetic only when the decision pair asks for it
   a_r3_arith_needs_mult: assert property (@(posedge clk) disable iff (rst)
      arith |-> mult);
   // R5: an arithmetic cycle is always followed by its shift
   a_r5_shift_after_arith: assert property (@(posedge clk) disable iff (rst)
      arith |=> shift);
   // R5: the step count never passes the operand width
   a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CW'(STEPS));
   // R6: done is a single pulse and never overlaps busy
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
      !(done && busy));
endmodule

// File: rtl/booth_seq_mult.sv
// Multi-cycle radix-2 Booth signed multiplier.
module booth_seq_mult #(
   parameter int W          = 9,
   parameter bit INVERT_ADD = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic [W-1:0]   multiplicand,
   input  logic [W-1:0]   multiplier,
   output logic           busy,
   output logic           done,
   output logic [2*W-1:0] product
);
   localparam int AW = W + 1;   // accumulator with guard bit

   generate
      if (W < 2) begin : g_bad_w
         $error("booth_seq_mult: W must be at least 2");
      end
   endgenerate

   logic          init, arith, shift, mult, as_sub;
   logic          f_q;
   logic [W-1:0]  md_q;
   logic [W-1:0]  mr_q;
   logic [AW-1:0] acc_q;
   logic [AW-1:0] acc_din;
   logic [AW-1:0] sum;
   logic [AW-1:0] md_ext;

   // decision pair {LSB, F}: 01 add, 10 subtract, 00/11 nothing
   assign mult   = mr_q[0] ^ f_q;
   assign as_sub = mr_q[0] & ~f_q;
   assign md_ext = {md_q[W-1], md_q};
   assign acc_din = init ? '0 : sum;

   booth_ctrl #(.STEPS(W)) u_ctrl (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .mult  (mult),
      .init  (init),
      .arith (arith),
      .shift (shift),
      .busy  (busy),
      .done  (done)
   );

   booth_addsub #(.WIDTH(AW), .INVERT_ADD(INVERT_ADD)) u_addsub (
      .a   (acc_q),
      .b   (md_ext),
      .sub (as_sub),
      .q   (sum)
   );

   booth_shreg #(.WIDTH(AW)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .ld     (init | arith),
      .sright (shift),
      .din    (acc_din),
      .sin    (acc_q[AW-1]),
      .q      (acc_q)
   );

   booth_shreg #(.WIDTH(W)) u_mr (
      .clk    (clk),
      .rst    (rst),
      .ld     (init),
      .sright (shift),
      .din    (multiplier),
      .sin    (acc_q[0]),
      .q      (mr_q)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         md_q <= '0;
         f_q  <= 1'b0;
      end else begin
         if (init)
            md_q <= multiplicand;
         if (init)
            f_q <= 1'b0;
         else if (shift)
            f_q <= mr_q[0];
      end
   end

   assign product = {acc_q[W-1:0], mr_q};

   // R3: subtract cycle lowers the accumulator by the multiplicand
   a_r3_sub_result: assert property (@(posedge clk) disable iff (rst)
      (arith && mr_q[0] && !f_q) |=> acc_q == $past(acc_q) - $past(md_ext));
   // R3: add cycle raises the accumulator by the multiplicand
   a_r3_add_result: assert property (@(posedge clk) disable iff (rst)
      (arith && !mr_q[0] && f_q) |=> acc_q == $past(acc_q) + $past(md_ext));
   // R4: sign extension on shift
   a_r4_sign_keep: assert property (@(posedge clk) disable iff (rst)
      shift |=> acc_q[AW-1] == $past(acc_q[AW-1]));
   // R4: multiplier LSB moves into F
   a_r4_f_capture: assert property (@(posedge clk) disable iff (rst)
      shift |=> f_q == $past(mr_q[0]));
   // R7: latched multiplicand stays put while busy
   a_r7_operand_hold: assert property (@(posedge clk) disable iff (rst)
      busy |=> $stable(md_q));
endmodule

// File: tb/booth_seq_mult_bench.sv
module booth_seq_mult_bench;
   localparam int W = 9;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           start = 1'b0;
   logic [W-1:0]   mcand = '0;
   logic [W-1:0]   mplier = '0;
   logic           busy, done;
   logic [2*W-1:0] product;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] lfsr = 32'h1ACE_5EED;

   always #10 clk = ~clk;   // 50 MHz

   booth_seq_mult #(.W(W)) u_booth_seq_mult (
      .clk          (clk),
      .rst          (rst),
      .start        (start),
      .multiplicand (mcand),
      .multiplier   (mplier),
      .busy         (busy),
      .done         (done),
      .product      (product)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [2*W-1:0] exp_prod(input logic [W-1:0] a, input logic [W-1:0] b);
      int p;
      p = int'($signed(a)) * int'($signed(b));
      return p[2*W-1:0];
   endfunction

   function automatic int n_ops(input logic [W-1:0] b);
      int n = 0;
      logic prev = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (b[i] != prev) n++;
         prev = b[i];
      end
      return n;
   endfunction

   // starts at a negedge, ends at a negedge
   task automatic t_run(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
      int cyc = 0;
      logic [2*W-1:0] e;
      e = exp_prod(a, b);
      mcand = a; mplier = b; start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0; mcand = ~a; mplier = ~b;   // R7: later input changes have no effect
      while (!done && cyc < 100) begin
         @(posedge clk); @(negedge clk);
         cyc++;
      end
      chk(cyc == W + n_ops(b), "R5 latency", cyc, W + n_ops(b));
      chk(product == e, req, longint'($signed(product)), longint'($signed(e)));
      chk(!busy, "R6 busy low with done", busy, 0);
      @(posedge clk); @(negedge clk);
      chk(!done, "R6 done one cycle", done, 0);
      repeat (3) @(negedge clk);
      chk(product == e, "R6 product held", longint'($signed(product)), longint'($signed(e)));
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      chk(!busy && !done, "R1 flags after reset", {busy, done}, 0);
      chk(product == '0, "R1 product after reset", product, 0);
   endtask

   task automatic t_directed();
      t_run(9'd0, 9'd0, "R2 zero");
      t_run(9'd1, 9'd1, "R2 one");
      t_run(9'h1FF, 9'h1FF, "R2 minus one squared");
      t_run(9'd255, 9'd255, "R2 max positive");
      t_run(9'h1FB, 9'h1FD, "R2 -5 x -3");
      t_run(9'd5, 9'h1FD, "R2 5 x -3");
      t_run(9'h0AA, 9'h155, "R3 alternating bits");
      t_run(9'h100, 9'h100, "R8 min x min");
      t_run(9'h100, 9'd255, "R8 min x max");
      t_run(9'h100, 9'd1, "R8 min x one");
      t_run(9'h100, 9'h1FF, "R8 min x minus one");
      t_run(9'd255, 9'h100, "R2 max x min");
   endtask

   task automatic t_random(input int count);
      for (int k = 0; k < count; k++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         t_run(lfsr[8:0], lfsr[24:16], "R2 pseudo-random");
      end
   endtask

   task automatic t_start_busy();
      int cyc = 0;
      logic [W-1:0] a = 9'd77;
      logic [W-1:0] b = 9'h155;
      mcand = a; mplier = b; start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      while (!done && cyc < 100) begin
         if (cyc == 3 || cyc == 8) begin
            start = 1'b1; mcand = 9'd3; mplier = 9'd2;
         end else begin
            start = 1'b0;
         end
         @(posedge clk); @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      chk(cyc == W + n_ops(b), "R7 latency unchanged", cyc, W + n_ops(b));
      chk(product == exp_prod(a, b), "R7 start while busy ignored",
          longint'($signed(product)), longint'($signed(exp_prod(a, b))));
      @(negedge clk);
   endtask

   task automatic t_mid_reset();
      mcand = 9'd100; mplier = 9'd99; start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      chk(busy, "R9 busy before reset", busy, 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!busy && !done, "R9 idle after reset", {busy, done}, 0);
      chk(product == '0, "R9 product cleared", product, 0);
      t_run(9'h1F0, 9'd33, "R9 operation after reset");
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_directed();
      t_start_busy();
      t_mid_reset();
      t_random(150);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule